// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block watches a port of input pins and turns selected pin conditions into one combined interrupt request. Each pin has its own sensing setup made from three control bits: a level-or-edge select, a polarity bit and a both-edges bit. Pins first pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one clock earlier.

Edge events are latched into a per-pin flag. The flag stays set until software writes a one to that pin's bit in the clear register. A level event does not latch: its status bit follows the pin while the chosen level is present. A per-pin enable mask gates the raw status into a masked status. The interrupt output is high while any masked bit is set.

Software reaches the block through a simple synchronous register port. A write takes effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, the level-select, polarity, both-edges and mask registers read zero, raw and masked status read zero, and irq_o is low.
- R2: A pin whose level-select bit is 1 has raw status 1 exactly while its synchronised value equals its polarity bit (1 = high level, 0 = low level). The status follows the pin both ways.
- R3: A pin whose level-select bit is 0 and whose both-edges bit is 0 latches its raw flag on a rising edge if its polarity bit is 1, and on a falling edge if it is 0. The flag is visible within four clocks of the pin change.
- R4: On an edge-sensed pin with its both-edges bit set, every transition latches the flag, whatever the polarity bit holds.
- R5: The mask register holds one enable bit per pin. Masked status reads as raw status AND mask.
- R6: irq_o is high exactly while at least one masked status bit is 1. With the mask at zero, irq_o is low.
- R7: Writing 1 to a bit of the clear register clears that pin's latched edge flag. Writing 0 leaves the flag alone. A flag that is not cleared keeps irq_o asserted.
- R8: A clear write does not remove a level-sensed pin's status while its qualifying level is still present.
- R9: When a new qualifying edge and a clear of the same pin land on the same clock edge, the flag stays set.
- R10: Register map (3-bit address): 0 level select, 1 polarity, 2 both-edges, 3 mask (all read/write); 4 raw status and 5 masked status (read-only); 6 clear (write-only, reads zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_i | input | NPINS | Asynchronous pin inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | NPINS | Register write data |
| reg_rdata_o | output | NPINS | Register read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong sensing bit or a corrupted previous-value register shows up in the raw status read within three to four clocks of the pin change, because the flag latches one clock after the second synchroniser stage. A bad mask or a bad OR-reduction shows up as a mismatch between the masked read and irq_o in the same cycle. A broken clear path shows up one clock after the clear write: either a flag that survives a one, or a flag lost to a zero or to a coincident edge. The same-cycle edge-and-clear case needs the clear timed onto the exact clock where the flag latches, and the bench times it that way.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned REG_ADDR_W = 3;
   typedef enum logic [REG_ADDR_W-1:0] {
      RA_LVLSEL  = 3'd0,
      RA_POL     = 3'd1,
      RA_ANYEDGE = 3'd2,
      RA_ENMASK  = 3'd3,
      RA_RAW     = 3'd4,
      RA_MASKED  = 3'd5,
      RA_CLEAR   = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned N      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int unsigned N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] sync_i,
   input  logic [N-1:0] lvl_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] any_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] hit_o,
   output logic [N-1:0] raw_o
);
   logic [N-1:0] prev_q;
   logic [N-1:0] flag_q;
   logic [N-1:0] flag_d;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= sync_i;
         flag_q <= flag_d;
      end
   end

   for (genvar i = 0; i < int'(N); i++) begin : g_pin
      logic rise, fall, edge_ok;
      assign rise    = sync_i[i] & ~prev_q[i];
      assign fall    = ~sync_i[i] & prev_q[i];
      assign edge_ok = any_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
      assign hit_o[i]  = ~lvl_i[i] & edge_ok;
      // new edge takes priority over a coincident clear
      assign flag_d[i] = lvl_i[i] ? 1'b0 : (hit_o[i] | (flag_q[i] & ~clr_i[i]));
      assign raw_o[i]  = lvl_i[i] ? ~(sync_i[i] ^ pol_i[i]) : flag_q[i];
   end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned N = 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [N-1:0]          wdata_i,
   input  logic [N-1:0]          raw_i,
   output logic [N-1:0]          lvl_o,
   output logic [N-1:0]          pol_o,
   output logic [N-1:0]          any_o,
   output logic [N-1:0]          mask_o,
   output logic [N-1:0]          clr_o,
   output logic [N-1:0]          masked_o,
   output logic [N-1:0]          rdata_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lvl_o  <= '0;
         pol_o  <= '0;
         any_o  <= '0;
         mask_o <= '0;
      end else if (wr_i) begin
         case (addr_i)
            RA_LVLSEL:  lvl_o  <= wdata_i;
            RA_POL:     pol_o  <= wdata_i;
            RA_ANYEDGE: any_o  <= wdata_i;
            RA_ENMASK:  mask_o <= wdata_i;
            default: ;
         endcase
      end
   end

   assign clr_o    = (wr_i && addr_i == RA_CLEAR) ? wdata_i : '0;
   assign masked_o = raw_i & mask_o;

   always_comb begin
      case (addr_i)
         RA_LVLSEL:  rdata_o = lvl_o;
         RA_POL:     rdata_o = pol_o;
         RA_ANYEDGE: rdata_o = any_o;
         RA_ENMASK:  rdata_o = mask_o;
         RA_RAW:     rdata_o = raw_i;
         RA_MASKED:  rdata_o = masked_o;
         default:    rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NPINS-1:0]      pin_i,
   input  logic                  reg_wr_i,
   input  logic [REG_ADDR_W-1:0] reg_addr_i,
   input  logic [NPINS-1:0]      reg_wdata_i,
   output logic [NPINS-1:0]      reg_rdata_o,
   output logic                  irq_o
);
   initial begin
      assert (NPINS >= 1 && NPINS <= 32) else $error("NPINS out of range");
      assert (SYNC_STAGES >= 2 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   logic [NPINS-1:0] sync_w, lvl_q, pol_q, any_q, mask_q, clr_w, hit_w, raw_w, masked_w;

   gpio_irq_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_w));

   gpio_irq_detect #(.N(NPINS)) u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_w), .lvl_i(lvl_q),
      .pol_i(pol_q), .any_i(any_q), .clr_i(clr_w), .hit_o(hit_w), .raw_o(raw_w));

   gpio_irq_regs #(.N(NPINS)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .raw_i(raw_w), .lvl_o(lvl_q), .pol_o(pol_q),
      .any_o(any_q), .mask_o(mask_q), .clr_o(clr_w), .masked_o(masked_w),
      .rdata_o(reg_rdata_o));

   assign irq_o = |masked_w;
endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk #(
   parameter int unsigned NPINS = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NPINS-1:0] lvl,
   input logic [NPINS-1:0] mask,
   input logic [NPINS-1:0] clr,
   input logic [NPINS-1:0] hit,
   input logic [NPINS-1:0] raw,
   input logic             irq
);
   // R6
   mask_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask == '0) |-> !irq);

   for (genvar i = 0; i < int'(NPINS); i++) begin : g_chk
      // R7
      w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!lvl[i] && clr[i] && !hit[i]) |=> (!raw[i] || lvl[i]));
      // R9
      edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!lvl[i] && hit[i]) |=> (raw[i] || lvl[i]));
      // R7
      flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!lvl[i] && raw[i] && !clr[i]) |=> (raw[i] || lvl[i]));
   end
endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.NPINS(NPINS)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .lvl(lvl_q), .mask(mask_q),
   .clr(clr_w), .hit(hit_w), .raw(raw_w), .irq(irq_o));

// File: tb/tb_gpio_irq_sense.sv
module tb_gpio_irq_sense;
   localparam int N = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] pin = '0;
   logic wr = 1'b0;
   logic [2:0] addr = '0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] rdata;
   logic irq;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gpio_irq_sense #(.NPINS(N)) dut (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_wr_i(wr),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

   // fields: lvl pol any mask pins_a pins_b exp_raw exp_irq
   localparam logic [63:0] VEC [8] = '{
      64'h00_FF_00_FF_00_0F_0F_01,  // R3 rising
      64'h00_00_00_FF_FF_F0_0F_01,  // R3 falling
      64'h00_00_FF_FF_0F_F0_FF_01,  // R4 both edges
      64'hFF_FF_00_FF_00_A5_A5_01,  // R2 high level
      64'hFF_00_00_FF_00_A5_5A_01,  // R2 low level
      64'h00_FF_00_00_00_0F_0F_00,  // R6 mask off
      64'hF0_CC_03_0F_00_FF_CF_01,  // R5 mixed
      64'hF0_CC_03_F0_FF_00_33_01   // R5 mixed falling
   };

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic wait_clk(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] v;
      wait_clk(3);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rreg(3'(a), v); chk("R1", v, '0);
      end
      chk("R1 irq", {7'd0, irq}, 8'd0);

      for (int t = 0; t < 8; t++) begin
         logic [63:0] e;
         e = VEC[t];
         wreg(3'd0, e[63:56]); wreg(3'd1, e[55:48]);
         wreg(3'd2, e[47:40]); wreg(3'd3, e[39:32]);
         @(negedge clk); pin = e[31:24];
         wait_clk(5);
         wreg(3'd6, 8'hFF);
         @(negedge clk); pin = e[23:16];
         wait_clk(5);
         rreg(3'd4, v); chk($sformatf("R2/R3/R4 raw vec%0d", t), v, e[15:8]);
         rreg(3'd5, v); chk($sformatf("R5 masked vec%0d", t), v, e[15:8] & e[39:32]);
         chk($sformatf("R6 irq vec%0d", t), {7'd0, irq}, e[7:0]);
      end

      // R10 clear register reads zero, config registers read back
      rreg(3'd6, v); chk("R10 clear reads 0", v, '0);
      rreg(3'd1, v); chk("R10 pol readback", v, 8'hCC);

      // R7 / R9 on pin 0, rising edge sensed
      wreg(3'd0, 8'h00); wreg(3'd1, 8'h01); wreg(3'd2, 8'h00); wreg(3'd3, 8'h01);
      @(negedge clk); pin = 8'h00;
      wait_clk(5);
      wreg(3'd6, 8'hFF);
      @(negedge clk); pin = 8'h01;
      @(posedge clk); @(posedge clk);
      @(negedge clk); wr = 1'b1; addr = 3'd6; wdata = 8'h01;
      @(negedge clk); wr = 1'b0;
      rreg(3'd4, v); chk("R9 edge beats clear", v, 8'h01);
      wreg(3'd6, 8'h00);
      wait_clk(4);
      rreg(3'd4, v); chk("R7 write 0 no effect", v, 8'h01);
      chk("R7 irq held", {7'd0, irq}, 8'd1);
      wreg(3'd6, 8'h01);
      rreg(3'd4, v); chk("R7 w1c clears", v, 8'h00);
      chk("R7 irq drops", {7'd0, irq}, 8'd0);

      // R8 level pin 1, high level
      wreg(3'd0, 8'h02); wreg(3'd1, 8'h02); wreg(3'd3, 8'h02);
      @(negedge clk); pin = 8'h03;
      wait_clk(4);
      wreg(3'd6, 8'h02);
      rreg(3'd4, v); chk("R8 level survives clear", v & 8'h02, 8'h02);
      chk("R8 irq", {7'd0, irq}, 8'd1);
      @(negedge clk); pin = 8'h01;
      wait_clk(3);
      rreg(3'd4, v); chk("R2 level follows pin", v & 8'h02, 8'h00);
      chk("R6 irq off", {7'd0, irq}, 8'd0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule